// File: doc/BRIEF.md
# MMU control register file

This block is a bank of memory-management and exception control registers on a simple CPU register bus. It holds nine registers:

- the MMU control word;
- the page-table entry high, low and assistance words;
- the translation table base;
- the exception address;
- the trap, exception-event and interrupt-event codes.

Each register keeps only the bits it defines. Unused bits read back as zero.

Two writes also send a one-clock command pulse to the translation buffer. Writing the control word with its invalidate bit set gives an invalidate pulse, and the bit itself is never stored. Writing the entry-high word with a new address-space identifier (its low byte) gives a flush pulse.

Beside the bank sits a decoder for the memory-mapped cache and TLB array window. It turns bits 26:24 of a window-relative address into one of eight region selects, and passes the low 24 bits on as the offset into that array. The arrays themselves live elsewhere.

Register accesses take effect on the clock edge where `wr_en` or `rd_en` is sampled high. Read data and the error flag appear in the cycle after that edge.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset every register reads 0, and `inval_pulse`, `flush_pulse` and `err` are 0.
- R2: A write to the control word (offset 0x00) stores `wdata` with bit 2 forced to 0; a later read returns that value, so bit 2 always reads 0.
- R3: A control-word write with `wdata[2]`=1 drives `inval_pulse` high for exactly the one cycle after the write edge; with `wdata[2]`=0 no pulse occurs.
- R4: The entry-high word (offset 0x04) stores all 32 bits and `asid` shows its bits 7:0. A write whose bits 7:0 differ from the stored ones drives `flush_pulse` high for the one cycle after the write edge; a write with an equal low byte gives no pulse.
- R5: The assistance word (offset 0x20) keeps only bits 3:0; higher bits read 0.
- R6: The trap (0x14), exception-event (0x18) and interrupt-event (0x1C) words keep only bits 10:0; higher bits read 0.
- R7: The entry-low (0x08), table-base (0x0C) and exception-address (0x10) words store and return all 32 bits.
- R8: A read or write at any other offset reads 0, drives `err` high for the one cycle after the access, and changes no register. Accesses at mapped offsets leave `err` low.
- R9: With `arr_en`=1, `arr_sel` has exactly one bit set: the bit numbered by `arr_addr[26:24]`. Index 0 is instruction cache address, then instruction cache data, instruction TLB address, instruction TLB data, operand cache address, operand cache data, unified TLB address, and 7 is unified TLB data. With `arr_en`=0, `arr_sel` is 0. `arr_offs` equals `arr_addr[23:0]` at all times.
- R10: `rdata` changes only in the cycle after a read edge and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| err | output | 1 | One-cycle flag for an access at an unmapped offset |
| inval_pulse | output | 1 | One-cycle translation buffer invalidate command |
| flush_pulse | output | 1 | One-cycle flush command on an identifier change |
| asid | output | 8 | Current address-space identifier |
| arr_en | input | 1 | Array window access valid |
| arr_addr | input | 27 | Window-relative array address |
| arr_sel | output | 8 | One-hot array region select |
| arr_offs | output | 24 | Offset inside the selected array |

## Verification
Control-word writes are tried with the invalidate bit set and clear, carrying otherwise identical data. This separates the pulse condition from the value that is stored.

Entry-high writes repeat the same low byte with different upper bits, then change only the low byte. This shows that the flush follows the identifier alone and not the whole word.

Every register is written all-ones and read back, which exposes each field mask. Each unmapped offset is hit by both a read and a write, followed by a reread of a neighbour register, so a stray write would be seen.

All eight region codes go through the decoder with varied surrounding bits, and the decoder is also tried with the enable low.

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ASID_W    = 8,
  parameter int EVT_W     = 11,
  parameter int PTEA_W    = 4,
  parameter int INVAL_BIT = 2,
  parameter logic [ADDR_W-1:0] OFF_CTL    = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_PTEH   = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_PTEL   = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_TBASE  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_EXCA   = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_TRAP   = 8'h14,
  parameter logic [ADDR_W-1:0] OFF_EXPEVT = 8'h18,
  parameter logic [ADDR_W-1:0] OFF_INTEVT = 8'h1C,
  parameter logic [ADDR_W-1:0] OFF_PTEA   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              inval_pulse,
  output logic              flush_pulse,
  output logic [ASID_W-1:0] asid,
  input  logic              arr_en,
  input  logic [26:0]       arr_addr,
  output logic [7:0]        arr_sel,
  output logic [23:0]       arr_offs
);
  localparam int NREG = 9;
  localparam logic [DATA_W-1:0] CTL_MASK = ~(DATA_W'(1) << INVAL_BIT);

  logic [NREG-1:0]   hit;
  logic              mapped;
  logic [DATA_W-1:0] ctl_q, pteh_q, ptel_q, tbase_q, exca_q;
  logic [PTEA_W-1:0] ptea_q;
  logic [EVT_W-1:0]  trap_q, expevt_q, intevt_q;
  logic [DATA_W-1:0] rsel;

  assign hit[0] = addr == OFF_CTL;
  assign hit[1] = addr == OFF_PTEH;
  assign hit[2] = addr == OFF_PTEL;
  assign hit[3] = addr == OFF_TBASE;
  assign hit[4] = addr == OFF_EXCA;
  assign hit[5] = addr == OFF_TRAP;
  assign hit[6] = addr == OFF_EXPEVT;
  assign hit[7] = addr == OFF_INTEVT;
  assign hit[8] = addr == OFF_PTEA;
  assign mapped = |hit;

  wire wr_ctl  = wr_en && hit[0];
  wire wr_pteh = wr_en && hit[1];
  wire asid_ne = wdata[ASID_W-1:0] != pteh_q[ASID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      pteh_q   <= '0;
      ptel_q   <= '0;
      tbase_q  <= '0;
      exca_q   <= '0;
      trap_q   <= '0;
      expevt_q <= '0;
      intevt_q <= '0;
      ptea_q   <= '0;
    end else if (wr_en) begin
      if (hit[0]) ctl_q    <= wdata & CTL_MASK;
      if (hit[1]) pteh_q   <= wdata;
      if (hit[2]) ptel_q   <= wdata;
      if (hit[3]) tbase_q  <= wdata;
      if (hit[4]) exca_q   <= wdata;
      if (hit[5]) trap_q   <= wdata[EVT_W-1:0];
      if (hit[6]) expevt_q <= wdata[EVT_W-1:0];
      if (hit[7]) intevt_q <= wdata[EVT_W-1:0];
      if (hit[8]) ptea_q   <= wdata[PTEA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval_pulse <= 1'b0;
      flush_pulse <= 1'b0;
      err         <= 1'b0;
      rdata       <= '0;
    end else begin
      inval_pulse <= wr_ctl && wdata[INVAL_BIT];
      flush_pulse <= wr_pteh && asid_ne;
      err         <= (wr_en || rd_en) && !mapped;
      if (rd_en) rdata <= rsel;
    end
  end

  always_comb begin
    rsel = '0;
    unique case (1'b1)
      hit[0]:  rsel = ctl_q;
      hit[1]:  rsel = pteh_q;
      hit[2]:  rsel = ptel_q;
      hit[3]:  rsel = tbase_q;
      hit[4]:  rsel = exca_q;
      hit[5]:  rsel = DATA_W'(trap_q);
      hit[6]:  rsel = DATA_W'(expevt_q);
      hit[7]:  rsel = DATA_W'(intevt_q);
      hit[8]:  rsel = DATA_W'(ptea_q);
      default: rsel = '0;
    endcase
  end

  assign asid     = pteh_q[ASID_W-1:0];
  assign arr_sel  = arr_en ? (8'd1 << arr_addr[26:24]) : 8'd0;
  assign arr_offs = arr_addr[23:0];
endmodule

module mmu_ctl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int ASID_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CTL  = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_PTEH = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              w_inval,
  input logic [ASID_W-1:0] w_asid,
  input logic              rd_inval,
  input logic              err,
  input logic              inval_pulse,
  input logic              flush_pulse,
  input logic [ASID_W-1:0] asid,
  input logic              arr_en,
  input logic [2:0]        arr_rgn,
  input logic [7:0]        arr_sel
);
  a_r3_inval_cause: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> $past(wr_en && addr == OFF_CTL && w_inval));
  a_r3_inval_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTL && w_inval) |=> inval_pulse);
  a_r2_inval_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_CTL) |=> !rd_inval);
  a_r4_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(wr_en && addr == OFF_PTEH && w_asid != asid));
  a_r4_flush_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_PTEH && w_asid != asid) |=> flush_pulse);
  a_r4_asid_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_PTEH) |=> $stable(asid));
  a_r8_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en || rd_en));
  a_r8_no_err_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && (addr == OFF_CTL || addr == OFF_PTEH)) |=> !err);
  a_r9_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arr_sel));
  a_r9_sel_present: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |-> $countones(arr_sel) == 1);
  a_r9_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_en |-> arr_sel == 8'd0);
  a_r9_sel_top: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_en && arr_rgn == 3'd7) |-> arr_sel[7]);
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .ASID_W(ASID_W), .OFF_CTL(OFF_CTL), .OFF_PTEH(OFF_PTEH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .w_inval(wdata[INVAL_BIT]), .w_asid(wdata[ASID_W-1:0]),
  .rd_inval(rdata[INVAL_BIT]), .err(err), .inval_pulse(inval_pulse),
  .flush_pulse(flush_pulse), .asid(asid), .arr_en(arr_en),
  .arr_rgn(arr_addr[26:24]), .arr_sel(arr_sel)
);

// File: tb/mmu_ctl_regs_tb.sv
module mmu_ctl_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        err, inval_pulse, flush_pulse;
  logic [7:0]  asid;
  logic        arr_en = 0;
  logic [26:0] arr_addr = 0;
  logic [7:0]  arr_sel;
  logic [23:0] arr_offs;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mmu_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .inval_pulse(inval_pulse),
    .flush_pulse(flush_pulse), .asid(asid), .arr_en(arr_en),
    .arr_addr(arr_addr), .arr_sel(arr_sel), .arr_offs(arr_offs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    output logic iv, output logic fl, output logic er);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    iv = inval_pulse; fl = flush_pulse; er = err;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic er);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata; er = err;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic er;
    chk("R1 inval", {31'd0, inval_pulse}, 0);
    chk("R1 flush", {31'd0, flush_pulse}, 0);
    chk("R1 err", {31'd0, err}, 0);
    for (int i = 0; i <= 8; i++) begin
      rd(8'(i * 4), d, er);
      chk("R1 reset value", d, 0);
    end
  endtask

  task automatic t_ctl;
    logic iv, fl, er; logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF, iv, fl, er);
    chk("R3 pulse on set bit", {31'd0, iv}, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", {31'd0, inval_pulse}, 0);
    rd(8'h00, d, er);
    chk("R2 bit2 cleared", d, 32'hFFFF_FFFB);
    wr(8'h00, 32'h1234_5673, iv, fl, er);
    chk("R3 no pulse bit clear", {31'd0, iv}, 0);
    rd(8'h00, d, er);
    chk("R2 stored", d, 32'h1234_5673);
    chk("R8 no err mapped", {31'd0, er}, 0);
  endtask

  task automatic t_pteh;
    logic iv, fl, er; logic [31:0] d;
    wr(8'h04, 32'hAAAA_5511, iv, fl, er);
    chk("R4 flush on change", {31'd0, fl}, 1);
    chk("R4 asid", {24'd0, asid}, 32'h11);
    @(negedge clk);
    chk("R4 flush one cycle", {31'd0, flush_pulse}, 0);
    wr(8'h04, 32'h0F0F_0011, iv, fl, er);
    chk("R4 no flush same asid", {31'd0, fl}, 0);
    rd(8'h04, d, er);
    chk("R4 full store", d, 32'h0F0F_0011);
    wr(8'h04, 32'h0F0F_0012, iv, fl, er);
    chk("R4 flush low byte", {31'd0, fl}, 1);
    chk("R4 asid new", {24'd0, asid}, 32'h12);
  endtask

  task automatic t_masks;
    logic iv, fl, er; logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF, iv, fl, er);
    rd(8'h20, d, er);
    chk("R5 assist mask", d, 32'h0000_000F);
    for (int i = 0; i < 3; i++) begin
      wr(8'(8'h14 + i * 4), 32'hFFFF_FFFF, iv, fl, er);
      rd(8'(8'h14 + i * 4), d, er);
      chk("R6 event mask", d, 32'h0000_07FF);
    end
    wr(8'h18, 32'h0000_0A5C, iv, fl, er);
    rd(8'h18, d, er);
    chk("R6 event value", d, 32'h0000_025C);
    for (int i = 0; i < 3; i++) begin
      wr(8'(8'h08 + i * 4), 32'hDEAD_BEEF ^ 32'(i), iv, fl, er);
      rd(8'(8'h08 + i * 4), d, er);
      chk("R7 full word", d, 32'hDEAD_BEEF ^ 32'(i));
    end
  endtask

  task automatic t_unmapped;
    logic iv, fl, er; logic [31:0] d;
    logic [7:0] bad [3] = '{8'h24, 8'h02, 8'hFC};
    for (int i = 0; i < 3; i++) begin
      wr(bad[i], 32'hFFFF_FFFF, iv, fl, er);
      chk("R8 err on write", {31'd0, er}, 1);
      @(negedge clk);
      chk("R8 err one cycle", {31'd0, err}, 0);
      rd(bad[i], d, er);
      chk("R8 read zero", d, 0);
      chk("R8 err on read", {31'd0, er}, 1);
    end
    rd(8'h00, d, er);
    chk("R8 ctl untouched", d, 32'h1234_5673);
    rd(8'h20, d, er);
    chk("R8 assist untouched", d, 32'h0000_000F);
  endtask

  task automatic t_array;
    logic [26:0] a;
    for (int r = 0; r < 8; r++) begin
      a = {3'(r), 24'h5A5A5A ^ 24'(r * 24'h111111)};
      @(negedge clk);
      arr_en = 1; arr_addr = a;
      #1;
      chk("R9 select", {24'd0, arr_sel}, 32'(8'd1 << r));
      chk("R9 offset", {8'd0, arr_offs}, {8'd0, a[23:0]});
    end
    @(negedge clk);
    arr_en = 0; arr_addr = 27'h7FF_FFFF;
    #1;
    chk("R9 idle", {24'd0, arr_sel}, 0);
  endtask

  task automatic t_hold;
    logic [31:0] d; logic er;
    rd(8'h0C, d, er);
    chk("R10 read", d, 32'hDEAD_BEEE);
    @(negedge clk);
    addr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 holds", rdata, 32'hDEAD_BEEE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_ctl;
    t_pteh;
    t_masks;
    t_unmapped;
    t_array;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule